// File: doc/BRIEF.md
# GPIO Port Controller

A sixteen-pin general-purpose I/O port controlled through a 32-bit register bus. Each pin can be an input, a software-driven output, an output driven by one of sixteen alternate-function sources, or an analog pin. Output type, slew speed and pull resistor can be set per pin, and these settings go straight to the pad signals. A write-only set/clear word changes single output bits in one write, with no read-modify-write.

The bus is a single-cycle slave addressed by word index (byte offset divided by four). A write is taken at the rising clock edge when `bus_sel` and `bus_wr` are both high. Read data is combinational: it is valid in the same cycle that `bus_sel` is high with `bus_wr` low, and it is zero at all other times. Pad inputs pass through a two-flop synchroniser before software can read them.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low and after reset, every register reads zero, and `pad_oe`, `pad_out`, `pad_od`, `pad_analog`, `pad_pull` and `pad_speed` are all zero.
- R2: The word at index 0 (byte 0x00) holds two mode bits per pin at bits [2p+1:2p] and reads back as written. Mode 0 (input) gives oe=0 and out=0. Mode 1 (output) gives oe=1 and out equal to the output data bit. Mode 2 (alternate) gives oe=1 and out equal to `fn_src[16p+sel]`. Mode 3 (analog) gives oe=0, out=0 and `pad_analog[p]=1`.
- R3: The word at index 1 (0x04) holds one output-type bit per pin in bits [15:0], where 1 means open-drain, and this bit drives `pad_od[p]`. Bits [31:16] read zero.
- R4: The word at index 2 (0x08) holds a two-bit speed code per pin at [2p+1:2p]. It reads back as written and drives `pad_speed`.
- R5: The word at index 3 (0x0C) holds a two-bit pull code per pin: 0 none, 1 pull-up, 2 pull-down. It reads back as written. The reserved code 3 drives 00 (no pull) on `pad_pull`.
- R6: Reading index 4 (0x10) returns, in bits [15:0], pad levels that passed two flops. A level that is stable across two rising edges is visible. Pins in analog mode read 0. Writes to this index change nothing.
- R7: The word at index 5 (0x14) holds the output data bits [15:0] and reads back as written. Bits [31:16] read zero.
- R8: A write to index 6 (0x18) sets output bit n when wdata[n] is 1, and clears it when wdata[n+16] is 1 and wdata[n] is 0. When both bits are 1, set wins. A bit with neither set leaves the output unchanged. This index reads zero.
- R9: Pin p takes its 4-bit alternate-function select from the word at index 8+(p/8) (0x20 or 0x24), at bits [(p mod 8)*4+3:(p mod 8)*4]. Both words read back as written.
- R10: Unmapped indices (7 and 10 to 15) read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pad_in | input | 16 | Raw pad levels |
| fn_src | input | 256 | Alternate-function sources, 16 per pin, pin p at [16p+15:16p] |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |
| pad_od | output | 16 | Per-pin open-drain select |
| pad_pull | output | 32 | Per-pin pull code, 2 bits each |
| pad_speed | output | 32 | Per-pin speed code, 2 bits each |
| pad_analog | output | 16 | Per-pin analog mode flag |

## Verification
The assertions check on every cycle that a pin never shows analog and output-enable together and that the pull pins never carry the reserved code. They also check, on every write, that a set/clear write leaves set bits high, clears only the bits asked for, leaves all other bits unchanged, and reads back as zero, and that an input-data write leaves the mode and output data unchanged. The bench scenarios cover what needs a register model: readback of every word after random writes, the alternate-function select picking the right source for each pin, the two-edge input latency with analog masking, and the reset state.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'd0,
        PM_OUTPUT = 2'd1,
        PM_ALTFN  = 2'd2,
        PM_ANALOG = 2'd3
    } pin_mode_e;

    localparam logic [3:0] W_MODE  = 4'd0;
    localparam logic [3:0] W_OTYPE = 4'd1;
    localparam logic [3:0] W_SPEED = 4'd2;
    localparam logic [3:0] W_PULL  = 4'd3;
    localparam logic [3:0] W_IDATA = 4'd4;
    localparam logic [3:0] W_ODATA = 4'd5;
    localparam logic [3:0] W_SETCL = 4'd6;
    localparam logic [3:0] W_AFLO  = 4'd8;
    localparam logic [3:0] W_AFHI  = 4'd9;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= raw_in;
            sync_out <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int AF_W     = 4,
    parameter int DATA_W   = 32,
    parameter int WIDX_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WIDX_W-1:0]        word_idx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NUM_PINS-1:0]      in_data,
    output logic [2*NUM_PINS-1:0]    mode_q,
    output logic [NUM_PINS-1:0]      otype_q,
    output logic [2*NUM_PINS-1:0]    speed_q,
    output logic [2*NUM_PINS-1:0]    pull_q,
    output logic [NUM_PINS-1:0]      odr_q,
    output logic [AF_W*NUM_PINS-1:0] afsel_q,
    output logic [DATA_W-1:0]        rd_word
);
    localparam int FIELD2_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] set_bits;
    logic [NUM_PINS-1:0] clr_bits;

    assign set_bits = wdata[NUM_PINS-1:0];
    assign clr_bits = wdata[FIELD2_W-1:NUM_PINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            otype_q <= '0;
            speed_q <= '0;
            pull_q  <= '0;
            odr_q   <= '0;
            afsel_q <= '0;
        end else if (wr_en) begin
            case (word_idx)
                W_MODE:  mode_q  <= wdata[FIELD2_W-1:0];
                W_OTYPE: otype_q <= wdata[NUM_PINS-1:0];
                W_SPEED: speed_q <= wdata[FIELD2_W-1:0];
                W_PULL:  pull_q  <= wdata[FIELD2_W-1:0];
                W_ODATA: odr_q   <= wdata[NUM_PINS-1:0];
                W_SETCL: odr_q   <= (odr_q & ~clr_bits) | set_bits;
                W_AFLO:  afsel_q[DATA_W-1:0] <= wdata;
                W_AFHI:  afsel_q[2*DATA_W-1:DATA_W] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (word_idx)
            W_MODE:  rd_word[FIELD2_W-1:0] = mode_q;
            W_OTYPE: rd_word[NUM_PINS-1:0] = otype_q;
            W_SPEED: rd_word[FIELD2_W-1:0] = speed_q;
            W_PULL:  rd_word[FIELD2_W-1:0] = pull_q;
            W_IDATA: rd_word[NUM_PINS-1:0] = in_data;
            W_ODATA: rd_word[NUM_PINS-1:0] = odr_q;
            W_AFLO:  rd_word = afsel_q[DATA_W-1:0];
            W_AFHI:  rd_word = afsel_q[2*DATA_W-1:DATA_W];
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_pkg::*;
#(
    parameter int AF_W = 4,
    localparam int NUM_FN = 1 << AF_W
) (
    input  logic [1:0]        mode_sel,
    input  logic              odr_bit,
    input  logic              otype_bit,
    input  logic [1:0]        pull_cfg,
    input  logic [1:0]        speed_cfg,
    input  logic [AF_W-1:0]   af_sel,
    input  logic [NUM_FN-1:0] fn_src,
    input  logic              sync_bit,
    output logic              oe,
    output logic              out,
    output logic              od,
    output logic [1:0]        pull,
    output logic [1:0]        speed,
    output logic              analog,
    output logic              in_bit
);
    pin_mode_e md;
    assign md = pin_mode_e'(mode_sel);

    always_comb begin
        oe     = 1'b0;
        out    = 1'b0;
        analog = 1'b0;
        in_bit = sync_bit;
        unique case (md)
            PM_INPUT:  ;
            PM_OUTPUT: begin
                oe  = 1'b1;
                out = odr_bit;
            end
            PM_ALTFN: begin
                oe  = 1'b1;
                out = fn_src[af_sel];
            end
            PM_ANALOG: begin
                analog = 1'b1;
                in_bit = 1'b0;
            end
        endcase
    end

    assign od    = otype_bit;
    assign pull  = (pull_cfg == 2'b11) ? 2'b00 : pull_cfg;
    assign speed = speed_cfg;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int NUM_PINS = 16,
    parameter int AF_W     = 4,
    parameter int DATA_W   = 32,
    parameter int WIDX_W   = 4,
    localparam int NUM_FN  = 1 << AF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [WIDX_W-1:0]          bus_word,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pad_in,
    input  logic [NUM_PINS*NUM_FN-1:0] fn_src,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_od,
    output logic [2*NUM_PINS-1:0]      pad_pull,
    output logic [2*NUM_PINS-1:0]      pad_speed,
    output logic [NUM_PINS-1:0]        pad_analog
);
    logic [2*NUM_PINS-1:0]    cfg_mode;
    logic [NUM_PINS-1:0]      cfg_otype;
    logic [2*NUM_PINS-1:0]    cfg_speed;
    logic [2*NUM_PINS-1:0]    cfg_pull;
    logic [NUM_PINS-1:0]      cfg_odr;
    logic [AF_W*NUM_PINS-1:0] cfg_afsel;
    logic [NUM_PINS-1:0]      in_sync;
    logic [NUM_PINS-1:0]      in_masked;
    logic [DATA_W-1:0]        rd_word;

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (in_sync)
    );

    gpio_cfg_regs #(
        .NUM_PINS (NUM_PINS),
        .AF_W     (AF_W),
        .DATA_W   (DATA_W),
        .WIDX_W   (WIDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_sel & bus_wr),
        .word_idx (bus_word),
        .wdata    (bus_wdata),
        .in_data  (in_masked),
        .mode_q   (cfg_mode),
        .otype_q  (cfg_otype),
        .speed_q  (cfg_speed),
        .pull_q   (cfg_pull),
        .odr_q    (cfg_odr),
        .afsel_q  (cfg_afsel),
        .rd_word  (rd_word)
    );

    assign bus_rdata = (bus_sel && !bus_wr) ? rd_word : '0;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_drive #(.AF_W(AF_W)) u_pin (
            .mode_sel  (cfg_mode[2*p +: 2]),
            .odr_bit   (cfg_odr[p]),
            .otype_bit (cfg_otype[p]),
            .pull_cfg  (cfg_pull[2*p +: 2]),
            .speed_cfg (cfg_speed[2*p +: 2]),
            .af_sel    (cfg_afsel[AF_W*p +: AF_W]),
            .fn_src    (fn_src[NUM_FN*p +: NUM_FN]),
            .sync_bit  (in_sync[p]),
            .oe        (pad_oe[p]),
            .out       (pad_out[p]),
            .od        (pad_od[p]),
            .pull      (pad_pull[2*p +: 2]),
            .speed     (pad_speed[2*p +: 2]),
            .analog    (pad_analog[p]),
            .in_bit    (in_masked[p])
        );
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int WIDX_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [WIDX_W-1:0]     bus_word,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_analog,
    input logic [2*NUM_PINS-1:0] pad_pull,
    input logic [NUM_PINS-1:0]   cfg_odr,
    input logic [2*NUM_PINS-1:0] cfg_mode
);
    logic                wr_setcl, rd_setcl, wr_idata;
    logic [NUM_PINS-1:0] set_req, clr_req;

    assign wr_setcl = bus_sel && bus_wr && (bus_word == 4'd6);
    assign rd_setcl = bus_sel && !bus_wr && (bus_word == 4'd6);
    assign wr_idata = bus_sel && bus_wr && (bus_word == 4'd4);
    assign set_req  = bus_wdata[NUM_PINS-1:0];
    assign clr_req  = bus_wdata[2*NUM_PINS-1:NUM_PINS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (pad_oe == '0 && pad_analog == '0)
                else $error("pads active in reset"); // R1
        end
    end

    AST_SETCL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setcl |=> ((cfg_odr & $past(set_req)) == $past(set_req))); // R8
    AST_SETCL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setcl |=> ((cfg_odr & $past(clr_req & ~set_req)) == '0)); // R8
    AST_SETCL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setcl |=> (((cfg_odr ^ $past(cfg_odr)) & ~$past(set_req | clr_req)) == '0)); // R8
    AST_SETCL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_setcl |-> (bus_rdata == '0)); // R8
    AST_ANALOG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_analog) == '0)); // R2
    AST_IDATA_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idata |=> ($stable(cfg_odr) && $stable(cfg_mode))); // R6

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pull
        AST_PULL_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_pull[2*p +: 2] != 2'b11)); // R5
    end
endmodule

bind gpio_port gpio_port_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .WIDX_W   (WIDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_word   (bus_word),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_oe     (pad_oe),
    .pad_analog (pad_analog),
    .pad_pull   (pad_pull),
    .cfg_odr    (cfg_odr),
    .cfg_mode   (cfg_mode)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
    localparam int NP = 16;
    localparam int NF = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]    bus_word = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP*NF-1:0] fn_src = '0;
    logic [NP-1:0] pad_oe, pad_out, pad_od, pad_analog;
    logic [2*NP-1:0] pad_pull, pad_speed;

    int total = 0, bad = 0;
    bit done = 0;

    logic [31:0] m_mode, m_speed, m_pull;
    logic [15:0] m_otype, m_odr, m_in;
    logic [63:0] m_af;

    gpio_port dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string word_tag(input int w);
        case (w)
            0: return "R2 mode";  1: return "R3 otype"; 2: return "R4 speed";
            3: return "R5 pull";  4: return "R6 idata"; 5: return "R7 odata";
            6: return "R8 setclr"; 8, 9: return "R9 altfn";
            default: return "R10 unmapped";
        endcase
    endfunction

    function automatic logic [15:0] ana_mask();
        logic [15:0] m;
        for (int p = 0; p < NP; p++) m[p] = (m_mode[2*p +: 2] == 2'd3);
        return m;
    endfunction

    function automatic logic [31:0] exp_read(input int w);
        case (w)
            0: return m_mode;
            1: return {16'h0, m_otype};
            2: return m_speed;
            3: return m_pull;
            4: return {16'h0, m_in & ~ana_mask()};
            5: return {16'h0, m_odr};
            8: return m_af[31:0];
            9: return m_af[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input int w, input logic [31:0] d);
        case (w)
            0: m_mode = d;
            1: m_otype = d[15:0];
            2: m_speed = d;
            3: m_pull = d;
            5: m_odr = d[15:0];
            6: m_odr = (m_odr & ~d[31:16]) | d[15:0];
            8: m_af[31:0] = d;
            9: m_af[63:32] = d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 4'(w); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        model_write(w, d);
    endtask

    task automatic bus_read(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = 4'(w);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_word(input int w);
        logic [31:0] d;
        bus_read(w, d);
        check(word_tag(w), 256'(d), 256'(exp_read(w)));
    endtask

    task automatic check_all_words();
        for (int w = 0; w < 16; w++) check_word(w);
    endtask

    task automatic check_pads(input string tag);
        logic [15:0] e_oe, e_out, e_ana;
        logic [31:0] e_pull;
        #1;
        for (int p = 0; p < NP; p++) begin
            logic [1:0] md;
            logic [1:0] pl;
            md = m_mode[2*p +: 2];
            pl = m_pull[2*p +: 2];
            e_oe[p]  = (md == 2'd1) || (md == 2'd2);
            e_ana[p] = (md == 2'd3);
            e_out[p] = (md == 2'd1) ? m_odr[p] :
                       (md == 2'd2) ? fn_src[p*NF + int'(m_af[4*p +: 4])] : 1'b0;
            e_pull[2*p +: 2] = (pl == 2'd3) ? 2'd0 : pl;
        end
        check({tag, " R2 oe"}, 256'(pad_oe), 256'(e_oe));
        check({tag, " R2 R9 out"}, 256'(pad_out), 256'(e_out));
        check({tag, " R2 analog"}, 256'(pad_analog), 256'(e_ana));
        check({tag, " R3 od"}, 256'(pad_od), 256'(m_otype));
        check({tag, " R5 pull"}, 256'(pad_pull), 256'(e_pull));
        check({tag, " R4 speed"}, 256'(pad_speed), 256'(m_speed));
    endtask

    task automatic new_pad_in(input logic [15:0] v);
        @(negedge clk);
        pad_in = v;
        @(negedge clk);
        @(negedge clk);
        m_in = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int seed_ret;
        logic [31:0] d;
        seed_ret = int'($urandom(32'h5eed_0017));
        m_mode = '0; m_speed = '0; m_pull = '0; m_otype = '0; m_odr = '0; m_af = '0; m_in = '0;

        // R1: reset state while reset is held and after release
        repeat (3) @(negedge clk);
        check_pads("R1 in reset");
        bus_read(0, d); check("R1 mode in reset", 256'(d), 256'(0));
        rst_n = 1'b1;
        check_all_words();
        check_pads("R1 after reset");

        // R2: each mode in turn, with fn sources and output data
        fn_src = {8{$urandom()}};
        bus_write(5, 32'h0000_A5C3);
        bus_write(8, 32'h7654_3210);
        bus_write(9, 32'hFEDC_BA98);
        bus_write(0, 32'h5555_5555); check_pads("R2 all output");
        bus_write(0, 32'hAAAA_AAAA); check_pads("R2 all altfn");
        bus_write(0, 32'hFFFF_FFFF); check_pads("R2 all analog");
        bus_write(0, 32'hE4E4_E4E4); check_pads("R2 mixed");

        // R9: pin 15 selects source 15 only through the high word
        bus_write(0, 32'h8000_0000);
        fn_src = '0; fn_src[15*NF + 15] = 1'b1;
        bus_write(9, 32'hF000_0000); check_pads("R9 pin15 src15");
        check("R9 pin15 high", 256'(pad_out[15]), 256'(1));
        bus_write(9, 32'hE000_0000); check_pads("R9 pin15 src14");

        // R5: reserved pull code
        bus_write(3, 32'hFFFF_FFFF); check_pads("R5 reserved");
        check_word(3);

        // R8: set wins, zero write keeps, read zero
        bus_write(5, 32'h0000_00F0);
        bus_write(6, 32'h0003_0001); check_word(5);
        check("R8 set wins", 256'(m_odr), 256'(16'h00F1));
        bus_write(6, 32'h0000_0000); check_word(5);
        bus_write(6, 32'h00F0_0000); check_word(5);
        check_word(6);

        // R6: input latency, analog masking, write ignored
        bus_write(0, 32'h0000_000F);
        new_pad_in(16'hBEEF); check_word(4);
        bus_write(4, 32'hFFFF_FFFF); check_all_words();

        // R10: unmapped writes have no effect
        bus_write(7, 32'hFFFF_FFFF);
        bus_write(12, 32'h1234_5678);
        bus_write(15, 32'hFFFF_FFFF);
        check_all_words();

        // Random mixed traffic
        for (int i = 0; i < 250; i++) begin
            int w;
            w = int'($urandom_range(0, 15));
            fn_src = {$urandom(), $urandom(), $urandom(), $urandom(),
                      $urandom(), $urandom(), $urandom(), $urandom()};
            bus_write(w, $urandom());
            check_pads("rand");
            check_word(w);
            check_word(5);
            if (i % 10 == 0) begin
                new_pad_in(16'($urandom()));
                check_word(4);
            end
        end

        finish_run();
    end
endmodule